// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio N = 32·M + S. It uses the two-counter pulse-swallow scheme. A dual-modulus prescaler divides by 33 or by 32. A main counter counts prescaler periods. A swallow counter counts how many of those periods use the longer modulus. The prescaler is modelled in logic on the same clock so that the whole chain can be simulated cycle by cycle. Its modulus-control signal is also brought out as a port.

A control-register latch supplies a 10-bit M value and a 5-bit S value through a load strobe. Both counters reload from the latch only when an output cycle ends, so a new value never disturbs a cycle already in progress. Each complete division cycle produces one output pulse, one clock wide. A build parameter can place a fixed divide-by-8 enable stage in front of the chain. With it, the end-to-end ratio 8·(32·M + S) can be checked.

Top module: `pswallow_divider`

## Requirements
- R1: The modulus-control output `mod_ctl_o` is 1 while the swallow count is nonzero and 0 otherwise. A prescaler period spans 33 input clocks while it is 1 and 32 clocks while it is 0. In each output cycle it is therefore high for exactly 33·S clocks.
- R2: With `INCLUDE_PRE8` = 0, the number of input clocks from one `pulse_o` pulse to the next equals 32·M + S for the latched values. This holds at the range limits M = 32, M = 1023, S = 0 and S = 31, and at values in between.
- R3: `pulse_o` is high for exactly one clock per division cycle and is never high on two consecutive clocks.
- R4: A load accepted in the middle of an output cycle does not change that cycle's length. The new M and S take effect from the next reload, which happens on the clock where `pulse_o` rises.
- R5: A load whose M value is below 32 is ignored. The latched M and S keep their previous values, and the divide ratio is unchanged.
- R6: While `rst_i` is high, `pulse_o` and `mod_ctl_o` are 0. Reset sets the latch to M = 32 and S = 0, so after reset pulses repeat every 1024 clocks.
- R7: With `INCLUDE_PRE8` = 1, the chain advances once every 8 input clocks. Pulses are then 8·(32·M + S) clocks apart and are still one clock wide.
- R8: The main count never reaches zero, and the swallow count never exceeds the main count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock derived from the oscillator being divided |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | One-clock strobe that captures `m_val_i` and `s_val_i` |
| m_val_i | input | 10 | Main counter value M (binary, accepted only when 32 or above) |
| s_val_i | input | 5 | Swallow counter value S (binary, 0 to 31) |
| pulse_o | output | 1 | Divided output pulse, one clock wide per division cycle |
| mod_ctl_o | output | 1 | Modulus control: 1 selects divide-by-33, 0 selects divide-by-32 |

## Verification
The bench measures pulse-to-pulse distances at both range limits of M and S and at intermediate values. It also counts the clocks in each cycle during which modulus control is high. An off-by-one swallow count or a prescaler reload value that is one off would therefore show up directly as a wrong total. Each load is applied a few clocks into a cycle, and the interval in progress must still match the old ratio. A design that reloaded immediately would produce one interval of a mixed length. A load with M below 32 must leave two following intervals unchanged. A second instance with the divide-by-8 front stage checks that the enable gating neither stretches the pulse nor loses a factor of 8.

// File: rtl/ps_pkg.sv
package ps_pkg;
    // Default geometry of the divider chain
    localparam int PS_M_W   = 10;  // main counter width
    localparam int PS_S_W   = 5;   // swallow counter width
    localparam int PS_P_W   = 5;   // prescaler base modulus = 2**PS_P_W
    localparam int PS_M_MIN = 32;  // smallest legal main count
    localparam int PS_FRONT = 3;   // front stage divides by 2**PS_FRONT
endpackage

// File: rtl/ps_front_div.sv
module ps_front_div #(
    parameter int DIV_W = ps_pkg::PS_FRONT
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic ce_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + DIV_W'(1);
        ce_o  = &cnt_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    AST_FRONT_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
        ce_o |=> !ce_o); // R7
endmodule

// File: rtl/ps_prescaler.sv
module ps_prescaler #(
    parameter int P_W = ps_pkg::PS_P_W
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ce_i,
    input  logic mc_next_i,
    output logic tick_o
);
    localparam int PC_W = P_W + 1;
    localparam logic [PC_W-1:0] LOAD_LO = PC_W'((1 << P_W) - 1); // 32 clocks
    localparam logic [PC_W-1:0] LOAD_HI = PC_W'(1 << P_W);       // 33 clocks

    logic [PC_W-1:0] pc_d, pc_q;

    always_comb begin
        tick_o = (pc_q == '0);
        pc_d   = pc_q;
        if (ce_i) begin
            if (tick_o) pc_d = mc_next_i ? LOAD_HI : LOAD_LO;
            else        pc_d = pc_q - PC_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pc_q <= LOAD_LO;
        else       pc_q <= pc_d;
    end

    AST_PRESCALE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_q <= LOAD_HI); // R1
endmodule

// File: rtl/ps_swallow_ctrl.sv
module ps_swallow_ctrl #(
    parameter int M_W   = ps_pkg::PS_M_W,
    parameter int S_W   = ps_pkg::PS_S_W,
    parameter int M_MIN = ps_pkg::PS_M_MIN
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           ce_i,
    input  logic           tick_i,
    input  logic [M_W-1:0] m_lat_i,
    input  logic [S_W-1:0] s_lat_i,
    output logic           mc_next_o,
    output logic           mod_ctl_o,
    output logic           pulse_o
);
    localparam logic [M_W-1:0] M_ONE = M_W'(1);
    localparam logic [S_W-1:0] S_ONE = S_W'(1);

    typedef struct packed {
        logic [M_W-1:0] m_rem;
        logic [S_W-1:0] s_rem;
        logic           pulse;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        mc_next_o  = 1'b0;
        if (ce_i && tick_i) begin
            if (st_q.m_rem == M_ONE) begin
                st_d.m_rem = m_lat_i;
                st_d.s_rem = s_lat_i;
                st_d.pulse = 1'b1;
            end else begin
                st_d.m_rem = st_q.m_rem - M_ONE;
                if (st_q.s_rem != '0) st_d.s_rem = st_q.s_rem - S_ONE;
            end
            mc_next_o = (st_d.s_rem != '0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.m_rem <= M_W'(M_MIN);
            st_q.s_rem <= '0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mod_ctl_o = (st_q.s_rem != '0);
    assign pulse_o   = st_q.pulse;

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.pulse |=> !st_q.pulse); // R3
    AST_RELOAD_FROM_LATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.pulse |-> (st_q.m_rem == $past(m_lat_i) && st_q.s_rem == $past(s_lat_i))); // R4
    AST_MAIN_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.m_rem != '0); // R8
    AST_SWALLOW_LE_MAIN: assert property (@(posedge clk_i) disable iff (rst_i)
        M_W'(st_q.s_rem) <= st_q.m_rem); // R8
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
    parameter int M_W          = ps_pkg::PS_M_W,
    parameter int S_W          = ps_pkg::PS_S_W,
    parameter int P_W          = ps_pkg::PS_P_W,
    parameter int M_MIN        = ps_pkg::PS_M_MIN,
    parameter int FRONT_W      = ps_pkg::PS_FRONT,
    parameter int INCLUDE_PRE8 = 0
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           load_i,
    input  logic [M_W-1:0] m_val_i,
    input  logic [S_W-1:0] s_val_i,
    output logic           pulse_o,
    output logic           mod_ctl_o
);
    localparam logic [M_W-1:0] M_FLOOR = M_W'(M_MIN);

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [S_W-1:0] s;
    } lat_t;

    lat_t lat_d, lat_q;
    logic ce;
    logic tick;
    logic mc_next;

    always_comb begin
        lat_d = lat_q;
        if (load_i && (m_val_i >= M_FLOOR)) begin
            lat_d.m = m_val_i;
            lat_d.s = s_val_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lat_q.m <= M_FLOOR;
            lat_q.s <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    generate
        if (INCLUDE_PRE8 != 0) begin : g_front
            ps_front_div #(.DIV_W(FRONT_W)) u_front (
                .clk_i (clk_i),
                .rst_i (rst_i),
                .ce_o  (ce)
            );
        end else begin : g_bypass
            assign ce = 1'b1;
        end
    endgenerate

    ps_prescaler #(.P_W(P_W)) u_pre (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ce_i      (ce),
        .mc_next_i (mc_next),
        .tick_o    (tick)
    );

    ps_swallow_ctrl #(.M_W(M_W), .S_W(S_W), .M_MIN(M_MIN)) u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ce_i      (ce),
        .tick_i    (tick),
        .m_lat_i   (lat_q.m),
        .s_lat_i   (lat_q.s),
        .mc_next_o (mc_next),
        .mod_ctl_o (mod_ctl_o),
        .pulse_o   (pulse_o)
    );

    AST_LATCH_FLOOR: assert property (@(posedge clk_i) disable iff (rst_i)
        lat_q.m >= M_FLOOR); // R5
endmodule

// File: tb/pswallow_divider_tb.sv
module pswallow_divider_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load = 1'b0, load8 = 1'b0;
    logic [9:0] m_in = '0, m_in8 = '0;
    logic [4:0] s_in = '0, s_in8 = '0;
    logic pulse, mod, pulse8, mod8;

    int checks = 0, errors = 0;
    int cyc = 0;
    int npulse = 0, last_t = 0, last_int = 0, mc_run = 0, last_mc = 0, width_err = 0;
    int npulse8 = 0, last_t8 = 0, last_int8 = 0, width_err8 = 0;
    logic prev = 1'b0, prev8 = 1'b0;
    bit done8 = 1'b0;

    always #2 clk = ~clk;

    pswallow_divider u_dut (
        .clk_i(clk), .rst_i(rst), .load_i(load), .m_val_i(m_in), .s_val_i(s_in),
        .pulse_o(pulse), .mod_ctl_o(mod));

    pswallow_divider #(.INCLUDE_PRE8(1)) u_dut8 (
        .clk_i(clk), .rst_i(rst), .load_i(load8), .m_val_i(m_in8), .s_val_i(s_in8),
        .pulse_o(pulse8), .mod_ctl_o(mod8));

    always @(negedge clk) begin
        cyc++;
        if (!rst && pulse) begin
            if (npulse > 0) begin
                last_int = cyc - last_t;
                last_mc  = mc_run;
            end
            last_t = cyc;
            npulse++;
            mc_run = mod ? 1 : 0;
        end else if (!rst) begin
            mc_run += mod ? 1 : 0;
        end
        if (pulse && prev) width_err++;
        prev = pulse;
        if (!rst && pulse8) begin
            if (npulse8 > 0) last_int8 = cyc - last_t8;
            last_t8 = cyc;
            npulse8++;
        end
        if (pulse8 && prev8) width_err8++;
        prev8 = pulse8;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_pulses(input int n);
        int start = npulse;
        wait (npulse >= start + n);
    endtask

    task automatic wait_pulses8(input int n);
        int start = npulse8;
        wait (npulse8 >= start + n);
    endtask

    task automatic do_load(input int m, input int s);
        repeat (5) @(negedge clk);
        m_in = 10'(m); s_in = 5'(s); load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    int old_ratio = 1024;

    task automatic apply_cfg(input int m, input int s);
        int nr = 32 * m + s;
        do_load(m, s);
        wait_pulses(1);
        chk(last_int == old_ratio, "R4 cycle in progress keeps old ratio", last_int, old_ratio);
        wait_pulses(1);
        chk(last_int == nr, "R2 interval 32*M+S", last_int, nr);
        chk(last_mc == 33 * s, "R1 modulus-control high clocks 33*S", last_mc, 33 * s);
        old_ratio = nr;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main_seq
        repeat (4) @(negedge clk);
        chk(pulse == 1'b0, "R6 pulse low in reset", int'(pulse), 0);
        chk(mod == 1'b0, "R6 mod_ctl low in reset", int'(mod), 0);
        rst = 1'b0;
        wait_pulses(2);
        chk(last_int == 1024, "R6 reset ratio M=32 S=0", last_int, 1024);
        chk(last_mc == 0, "R1 no swallow at S=0", last_mc, 0);
        apply_cfg(32, 31);
        apply_cfg(100, 7);
        apply_cfg(500, 17);
        apply_cfg(32, 0);
        // R5: M below the floor must be ignored
        do_load(5, 3);
        wait_pulses(1);
        chk(last_int == old_ratio, "R5 rejected load leaves cycle", last_int, old_ratio);
        wait_pulses(1);
        chk(last_int == old_ratio, "R5 rejected load leaves ratio", last_int, old_ratio);
        chk(last_mc == 0, "R5 rejected load leaves S", last_mc, 0);
        apply_cfg(1023, 0);
        apply_cfg(1023, 31);
        chk(width_err == 0, "R3 pulse one clock wide", width_err, 0);
        chk(npulse > 10, "R3 pulses observed", npulse, 11);
        wait (done8);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : pre8_seq
        wait (!rst);
        wait_pulses8(2);
        chk(last_int8 == 8192, "R7 front stage reset ratio", last_int8, 8192);
        repeat (5) @(negedge clk);
        m_in8 = 10'd33; s_in8 = 5'd3; load8 = 1'b1;
        @(negedge clk);
        load8 = 1'b0;
        wait_pulses8(2);
        chk(last_int8 == 8 * (32 * 33 + 3), "R7 front stage ratio 8*(32*M+S)", last_int8, 8 * (32 * 33 + 3));
        chk(width_err8 == 0, "R7 front stage pulse one clock wide", width_err8, 0);
        done8 = 1'b1;
    end
endmodule